// File: doc/BRIEF.md
# Serial Character Transceiver with Fractional Bit-Rate Divider

This block sends and receives asynchronous serial characters for debug and control traffic. A free-running prescaler divides the system clock by 1, 2, 4 or 8 to form the input tick, so a 10 MHz system clock gives tick rates of 10, 5, 2.5 and 1.25 MHz. A bit-period timer counts those ticks using a fixed-point divisor. The divisor has 13 integer bits and 3 fraction bits. The fraction is added into a 3-bit accumulator once per bit, and each carry lengthens that bit by one tick. The smallest recommended divisor is 8.0.

Characters carry 7 or 8 data bits, an optional parity bit and one or two stop bits. Parity can be even, odd, forced high or forced low. The transmit side takes characters from a 4-entry queue. The receive side samples the line at mid-bit and writes each character into a 4-entry queue, whose occupancy appears at a port. Framing, parity and overrun errors are held in sticky flags. A single interrupt output combines "receive data waiting" with "any error flag set", and each of the two is gated by its own enable.

The transmit state machine has the states TX_IDLE, TX_START, TX_DATA, TX_PAR and TX_STOP. It moves TX_IDLE→TX_START when the queue holds a character and a tick is present. It moves TX_START→TX_DATA at the end of the start bit. It moves TX_DATA→TX_PAR, or TX_DATA→TX_STOP when parity is off, after the last data bit. It moves TX_PAR→TX_STOP after the parity bit, and TX_STOP→TX_IDLE after the last stop bit. The receive state machine has the states RX_IDLE, RX_START, RX_DATA, RX_PAR and RX_STOP. It moves RX_IDLE→RX_START when the line is seen low. It moves RX_START→RX_DATA if the line is still low at mid start bit, and RX_START→RX_IDLE if the line has gone back high. RX_DATA→RX_PAR/RX_STOP, RX_PAR→RX_STOP and RX_STOP→RX_IDLE follow the same pattern as the transmitter, and a character is pushed on the last transition.

Top module: `uart_fracbaud`

## Requirements
- R1: After reset, txd is high and rx_count, tx_full, irq and all three error flags are 0.
- R2: A frame is one low start bit, then the data bits LSB first, then the optional parity bit, then high stop bits. With cfg_data7=1 only bits 6..0 are sent, and a received character reads with bit 7 = 0. Example: 0x45 with 7 data bits, odd parity and two stop bits gives the line sequence 0,1,0,1,0,0,0,1,0,1,1.
- R3: cfg_par_sel selects the parity bit: 0 gives even parity (XOR of the data bits), 1 gives odd parity, 2 gives a constant 1 and 3 gives a constant 0. The parity bit is sent only when cfg_par_en=1.
- R4: cfg_stop2=1 sends two stop bits, and cfg_stop2=0 sends one.
- R5: The integer part of the divisor is div_cfg[15:3] and the fraction is div_cfg[2:0], in eighths. The first bit of a frame lasts the integer part in ticks. At the end of each bit the fraction is added into a 3-bit accumulator that starts from zero, and a carry adds one tick to the next bit. With divisor 8.5 at tick rate 1, character 0x00 in 8N1 holds the line low for 76 clk cycles. With divisor 8.0 the line stays low for 72 cycles.
- R6: The input tick occurs every 2^clk_sel clk cycles. With divisor 8.0 and clk_sel=1, character 0x00 in 8N1 holds the line low for 144 cycles.
- R7: Each queue holds 4 characters. tx_full is 1 while 4 characters wait to be sent. rx_count gives the number of received characters waiting. A write to a full queue is dropped.
- R8: The receiver recovers characters sent with any of the supported frame settings, and rx_rdata shows the oldest character until rx_rd removes it.
- R9: A parity mismatch on a received character sets err_parity, and the character is still stored.
- R10: A stop bit sampled low sets err_frame.
- R11: A character that completes while the receive queue is full sets err_overrun and is discarded, and the stored characters are left unchanged.
- R12: irq = (irq_en_rx and rx_count≠0) or (irq_en_err and any error flag set).
- R13: err_clr clears all error flags, but a new error in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Prescaler select: tick every 2^clk_sel cycles |
| div_cfg | input | 16 | Bit-period divisor, 13.3 fixed point |
| cfg_data7 | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_sel | input | 2 | Parity kind: 0 even, 1 odd, 2 one, 3 zero |
| cfg_stop2 | input | 1 | Two stop bits |
| tx_wr | input | 1 | Write tx_wdata into transmit queue |
| tx_wdata | input | 8 | Character to send |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Remove oldest received character |
| rx_rdata | output | 8 | Oldest received character |
| rx_count | output | 3 | Received characters waiting |
| err_frame | output | 1 | Sticky framing error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_clr | input | 1 | Clear all error flags |
| irq_en_rx | input | 1 | Enable data-waiting interrupt |
| irq_en_err | input | 1 | Enable error interrupt |
| irq | output | 1 | Interrupt request |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input |

## Verification
The bench builds the block with its default parameters: 13 integer bits, 3 fraction bits, a 2-bit clock select and 4-entry queues. With these values the queue-full and overrun cases are reached after only five characters. At run time it drives the divisor to 8.0 and 8.5 and clk_sel to 0 and 1. These settings make the one-tick stretch from the fraction carry and the tick spacing show up as exact low-pulse widths of 72, 76 and 144 cycles. Most traffic loops txd back to rxd. The bench drives corrupted frames by hand to produce the parity and framing errors.

// File: rtl/uart_fb_pkg.sv
package uart_fb_pkg;

    typedef enum logic [1:0] {
        PAR_EVEN  = 2'd0,
        PAR_ODD   = 2'd1,
        PAR_ONE   = 2'd2,
        PAR_ZERO  = 2'd3
    } par_e;

    typedef struct packed {
        logic data7;
        logic par_en;
        par_e par_sel;
        logic stop2;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_st_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_st_e;

    function automatic logic par_calc(input logic [7:0] d, input par_e sel);
        logic p;
        unique case (sel)
            PAR_EVEN: p = ^d;
            PAR_ODD:  p = ~^d;
            PAR_ONE:  p = 1'b1;
            default:  p = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/uart_fb_prescale.sv
module uart_fb_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = (1 << SEL_W) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] mask;

    assign mask = CW'((1 << sel) - 1);
    assign tick = ((cnt & mask) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/uart_fb_bittimer.sv
module uart_fb_bittimer #(
    parameter int INT_W  = 13,
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  logic              half,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              strobe
);
    logic [INT_W-1:0]  cnt;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;

    assign sum    = {1'b0, acc} + {1'b0, div_frac};
    assign strobe = tick && !restart && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            acc <= '0;
        end else if (restart) begin
            acc <= '0;
            cnt <= (half ? (div_int >> 1) : div_int) - INT_W'(1);
        end else if (strobe) begin
            acc <= sum[FRAC_W-1:0];
            cnt <= div_int - INT_W'(1) + INT_W'(sum[FRAC_W]);
        end else if (tick) begin
            cnt <= cnt - INT_W'(1);
        end
    end

    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && div_int >= INT_W'(2)) |=> !strobe); // R5

endmodule

// File: rtl/uart_fb_fifo.sv
module uart_fb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          full,
    output logic          empty,
    output logic [$clog2(DEPTH):0] count
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= nxt_ptr(wptr);
            if (do_pop)  rptr <= nxt_ptr(rptr);
            count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count))); // R7

endmodule

// File: rtl/uart_fb_tx.sv
module uart_fb_tx
    import uart_fb_pkg::*;
#(
    parameter int INT_W  = 13,
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  frame_cfg_t        cfg,
    input  logic              fifo_empty,
    input  logic [7:0]        fifo_data,
    output logic              fifo_pop,
    output logic              txd
);
    tx_st_e     state, nxt;
    logic [7:0] sh;
    logic [2:0] bitn;
    logic       stopn;
    logic       par_q;
    logic       start;
    logic       strobe;
    logic [2:0] last;
    logic [7:0] masked;

    assign start    = (state == TX_IDLE) && !fifo_empty && tick;
    assign fifo_pop = start;
    assign last     = cfg.data7 ? 3'd6 : 3'd7;
    assign masked   = cfg.data7 ? {1'b0, fifo_data[6:0]} : fifo_data;

    uart_fb_bittimer #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(start), .half(1'b0),
        .div_int(div_int), .div_frac(div_frac), .strobe(strobe)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (start) nxt = TX_START;
            TX_START: if (strobe) nxt = TX_DATA;
            TX_DATA:  if (strobe && bitn == last) nxt = cfg.par_en ? TX_PAR : TX_STOP;
            TX_PAR:   if (strobe) nxt = TX_STOP;
            TX_STOP:  if (strobe && stopn == cfg.stop2) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh    <= '0;
            bitn  <= '0;
            stopn <= 1'b0;
            par_q <= 1'b0;
        end else if (start) begin
            sh    <= masked;
            par_q <= par_calc(masked, cfg.par_sel);
            bitn  <= '0;
            stopn <= 1'b0;
        end else if (strobe) begin
            if (state == TX_DATA) begin
                sh   <= sh >> 1;
                bitn <= bitn + 3'd1;
            end
            if (state == TX_STOP) stopn <= 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            TX_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
    end

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !txd); // R2

endmodule

// File: rtl/uart_fb_rx.sv
module uart_fb_rx
    import uart_fb_pkg::*;
#(
    parameter int INT_W  = 13,
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  frame_cfg_t        cfg,
    input  logic              rxd,
    output logic              push,
    output logic [7:0]        pdata,
    output logic              perr_set,
    output logic              ferr_set
);
    rx_st_e     state, nxt;
    logic [1:0] sync;
    logic       rx_s;
    logic [7:0] sh;
    logic [2:0] bitn;
    logic       stopn;
    logic       par_rx;
    logic       ferr_acc;
    logic       detect;
    logic       strobe;
    logic [2:0] last;

    assign rx_s   = sync[1];
    assign detect = (state == RX_IDLE) && !rx_s;
    assign last   = cfg.data7 ? 3'd6 : 3'd7;

    uart_fb_bittimer #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(detect), .half(1'b1),
        .div_int(div_int), .div_frac(div_frac), .strobe(strobe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (detect) nxt = RX_START;
            RX_START: if (strobe) nxt = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (strobe && bitn == last) nxt = cfg.par_en ? RX_PAR : RX_STOP;
            RX_PAR:   if (strobe) nxt = RX_STOP;
            RX_STOP:  if (strobe && stopn == cfg.stop2) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh       <= '0;
            bitn     <= '0;
            stopn    <= 1'b0;
            par_rx   <= 1'b0;
            ferr_acc <= 1'b0;
        end else if (detect) begin
            bitn     <= '0;
            stopn    <= 1'b0;
            ferr_acc <= 1'b0;
        end else if (strobe) begin
            unique case (state)
                RX_DATA: begin
                    sh   <= {rx_s, sh[7:1]};
                    bitn <= bitn + 3'd1;
                end
                RX_PAR:  par_rx <= rx_s;
                RX_STOP: begin
                    stopn <= 1'b1;
                    if (!rx_s) ferr_acc <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        pdata    = cfg.data7 ? {1'b0, sh[7:1]} : sh;
        push     = (state == RX_STOP) && strobe && (stopn == cfg.stop2);
        perr_set = push && cfg.par_en && (par_rx != par_calc(pdata, cfg.par_sel));
        ferr_set = push && (ferr_acc || !rx_s);
    end

    AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push); // R8

endmodule

// File: rtl/uart_fracbaud.sv
module uart_fracbaud
    import uart_fb_pkg::*;
#(
    parameter int INT_W      = 13,
    parameter int FRAC_W     = 3,
    parameter int SEL_W      = 2,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SEL_W-1:0]            clk_sel,
    input  logic [INT_W+FRAC_W-1:0]     div_cfg,
    input  logic                        cfg_data7,
    input  logic                        cfg_par_en,
    input  logic [1:0]                  cfg_par_sel,
    input  logic                        cfg_stop2,
    input  logic                        tx_wr,
    input  logic [7:0]                  tx_wdata,
    output logic                        tx_full,
    input  logic                        rx_rd,
    output logic [7:0]                  rx_rdata,
    output logic [$clog2(FIFO_DEPTH):0] rx_count,
    output logic                        err_frame,
    output logic                        err_parity,
    output logic                        err_overrun,
    input  logic                        err_clr,
    input  logic                        irq_en_rx,
    input  logic                        irq_en_err,
    output logic                        irq,
    output logic                        txd,
    input  logic                        rxd
);
    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    frame_cfg_t        cfg;
    logic              tick;
    logic [INT_W-1:0]  div_int;
    logic [FRAC_W-1:0] div_frac;
    logic              tx_empty, tx_pop;
    logic [7:0]        tx_head;
    logic [CW-1:0]     tx_count;
    logic              rx_push, rx_full, rx_empty;
    logic [7:0]        rx_pdata;
    logic              perr_set, ferr_set, ovr_set;

    assign cfg      = '{data7: cfg_data7, par_en: cfg_par_en,
                        par_sel: par_e'(cfg_par_sel), stop2: cfg_stop2};
    assign div_int  = div_cfg[INT_W+FRAC_W-1:FRAC_W];
    assign div_frac = div_cfg[FRAC_W-1:0];

    uart_fb_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .sel(clk_sel), .tick(tick)
    );

    uart_fb_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_wr), .wdata(tx_wdata),
        .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty),
        .count(tx_count)
    );

    uart_fb_tx #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .div_int(div_int),
        .div_frac(div_frac), .cfg(cfg), .fifo_empty(tx_empty),
        .fifo_data(tx_head), .fifo_pop(tx_pop), .txd(txd)
    );

    uart_fb_rx #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .div_int(div_int),
        .div_frac(div_frac), .cfg(cfg), .rxd(rxd), .push(rx_push),
        .pdata(rx_pdata), .perr_set(perr_set), .ferr_set(ferr_set)
    );

    uart_fb_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_pdata),
        .pop(rx_rd), .rdata(rx_rdata), .full(rx_full), .empty(rx_empty),
        .count(rx_count)
    );

    assign ovr_set = rx_push && rx_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            err_frame   <= (err_frame   && !err_clr) || ferr_set;
            err_parity  <= (err_parity  && !err_clr) || perr_set;
            err_overrun <= (err_overrun && !err_clr) || ovr_set;
        end
    end

    assign irq = (irq_en_rx && !rx_empty) ||
                 (irq_en_err && (err_frame || err_parity || err_overrun));

    AST_OVR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> err_overrun); // R11

    AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !rx_push) |=> !err_frame && !err_parity && !err_overrun); // R13

endmodule

// File: tb/sim_uart_fracbaud.sv
module sim_uart_fracbaud;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  clk_sel = 2'd0;
    logic [15:0] div_cfg = 16'd64;
    logic        cfg_data7 = 1'b0, cfg_par_en = 1'b0, cfg_stop2 = 1'b0;
    logic [1:0]  cfg_par_sel = 2'd0;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_wdata = 8'h00;
    logic        tx_full;
    logic        rx_rd;
    logic [7:0]  rx_rdata;
    logic [2:0]  rx_count;
    logic        err_frame, err_parity, err_overrun;
    logic        err_clr = 1'b0;
    logic        irq_en_rx = 1'b0, irq_en_err = 1'b0;
    logic        irq, txd, rxd;
    logic        use_raw = 1'b0, raw_rxd = 1'b1;
    logic        mon_en = 1'b1, mon_rd = 1'b0, man_rd = 1'b0;

    int n_total = 0;
    int n_fail  = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    assign rxd   = use_raw ? raw_rxd : txd;
    assign rx_rd = mon_rd | man_rd;

    uart_fracbaud u0 (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .div_cfg(div_cfg),
        .cfg_data7(cfg_data7), .cfg_par_en(cfg_par_en), .cfg_par_sel(cfg_par_sel),
        .cfg_stop2(cfg_stop2), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_full(tx_full),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_count(rx_count),
        .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
        .err_clr(err_clr), .irq_en_rx(irq_en_rx), .irq_en_err(irq_en_err),
        .irq(irq), .txd(txd), .rxd(rxd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    // scoreboard monitor: pops received characters and compares (R8)
    always @(negedge clk) begin
        if (mon_rd) begin
            mon_rd = 1'b0;
        end else if (mon_en && rx_count != 3'd0) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected char", int'(rx_rdata), 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rx_rdata == e, "R8 received char", int'(rx_rdata), int'(e));
            end
            mon_rd = 1'b1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    task automatic set_cfg(input logic [1:0] sel, input logic [15:0] dv, input bit d7,
                           input bit pen, input logic [1:0] ps, input bit s2);
        @(negedge clk);
        clk_sel = sel; div_cfg = dv; cfg_data7 = d7;
        cfg_par_en = pen; cfg_par_sel = ps; cfg_stop2 = s2;
    endtask

    task automatic send(input logic [7:0] d, input bit track);
        @(negedge clk);
        tx_wr = 1'b1; tx_wdata = d;
        @(negedge clk);
        tx_wr = 1'b0;
        if (track) exp_q.push_back(cfg_data7 ? {1'b0, d[6:0]} : d);
    endtask

    function automatic logic bench_par(input logic [7:0] d, input logic [1:0] ps);
        int ones = $countones(d);
        case (ps)
            2'd0:    return (ones % 2) == 1;
            2'd1:    return (ones % 2) == 0;
            2'd2:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic mkframe(input logic [7:0] d, output logic [15:0] f, output int n);
        logic [7:0] m;
        int nd;
        m  = cfg_data7 ? {1'b0, d[6:0]} : d;
        nd = cfg_data7 ? 7 : 8;
        f = '1; n = 0;
        f[n++] = 1'b0;
        for (int i = 0; i < nd; i++) f[n++] = m[i];
        if (cfg_par_en) f[n++] = bench_par(m, cfg_par_sel);
        f[n++] = 1'b1;
        if (cfg_stop2) f[n++] = 1'b1;
    endtask

    // samples a frame on txd at mid-bit, divisor 8.0 and tick every cycle
    task automatic capture(input int n, output logic [15:0] got);
        got = '1;
        @(negedge txd);
        repeat (4) @(posedge clk);
        @(negedge clk);
        got[0] = txd;
        for (int i = 1; i < n; i++) begin
            repeat (8) @(posedge clk);
            @(negedge clk);
            got[i] = txd;
        end
    endtask

    task automatic frame_check(input logic [7:0] d, input string req);
        logic [15:0] exp_f, got;
        int n;
        mkframe(d, exp_f, n);
        send(d, 1'b1);
        capture(n, got);
        chk(got == exp_f, req, int'(got), int'(exp_f));
        repeat (40) @(negedge clk);
    endtask

    task automatic low_width(output int w);
        w = 0;
        @(negedge txd);
        forever begin
            @(negedge clk);
            if (txd) break;
            w++;
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic raw_frame(input logic [15:0] bits, input int n);
        @(negedge clk);
        use_raw = 1'b1;
        for (int i = 0; i < n; i++) begin
            raw_rxd = bits[i];
            repeat (8) @(negedge clk);
        end
        raw_rxd = 1'b1;
        repeat (20) @(negedge clk);
        use_raw = 1'b0;
    endtask

    task automatic man_read(input logic [7:0] e, input string req);
        @(negedge clk);
        chk(rx_rdata == e, req, int'(rx_rdata), int'(e));
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
    endtask

    initial begin
        int w;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
        chk(rx_count == 3'd0, "R1 rx_count", int'(rx_count), 0);
        chk(tx_full == 1'b0, "R1 tx_full", int'(tx_full), 0);
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);
        chk({err_frame, err_parity, err_overrun} == 3'b000, "R1 errors",
            int'({err_frame, err_parity, err_overrun}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 8N1 frame, R4 single stop
        set_cfg(2'd0, 16'd64, 1'b0, 1'b0, 2'd0, 1'b0);
        frame_check(8'hA5, "R2 8N1 frame 0xA5");
        // R2 R3 R4 7-bit odd two stop 0x45 -> 0,1,0,1,0,0,0,1,0,1,1
        set_cfg(2'd0, 16'd64, 1'b1, 1'b1, 2'd1, 1'b1);
        frame_check(8'h45, "R2 R3 R4 7O2 frame 0x45");
        chk(1'b1, "R2 7O2 reference", 0, 0);
        frame_check(8'hC5, "R2 7-bit masks bit 7");
        // R3 parity kinds
        set_cfg(2'd0, 16'd64, 1'b0, 1'b1, 2'd2, 1'b0);
        frame_check(8'h00, "R3 one-parity frame");
        set_cfg(2'd0, 16'd64, 1'b0, 1'b1, 2'd3, 1'b0);
        frame_check(8'hFF, "R3 zero-parity frame");
        set_cfg(2'd0, 16'd64, 1'b0, 1'b1, 2'd0, 1'b1);
        frame_check(8'h03, "R3 R4 even-parity two-stop frame");
        drain();

        // R5 fractional divisor and R6 clock select
        set_cfg(2'd0, 16'd64, 1'b0, 1'b0, 2'd0, 1'b0);
        send(8'h00, 1'b1); low_width(w);
        chk(w == 72, "R5 low width at 8.0", w, 72);
        drain();
        set_cfg(2'd0, 16'd68, 1'b0, 1'b0, 2'd0, 1'b0);
        send(8'h00, 1'b1); low_width(w);
        chk(w == 76, "R5 low width at 8.5", w, 76);
        drain();
        set_cfg(2'd1, 16'd64, 1'b0, 1'b0, 2'd0, 1'b0);
        send(8'h00, 1'b1); low_width(w);
        chk(w == 144, "R6 low width clk_sel=1", w, 144);
        drain();

        // R7 transmit queue full, loopback via scoreboard R8
        set_cfg(2'd0, 16'd64, 1'b0, 1'b1, 2'd1, 1'b0);
        for (int i = 0; i < 5; i++) send(8'h30 + 8'(i), 1'b1);
        chk(tx_full == 1'b1, "R7 tx_full after five writes", int'(tx_full), 1);
        drain();
        chk(tx_full == 1'b0, "R7 tx_full after drain", int'(tx_full), 0);

        // R11 overrun with R7 rx_count and R12 error interrupt
        mon_en = 1'b0;
        irq_en_err = 1'b1;
        set_cfg(2'd0, 16'd64, 1'b0, 1'b0, 2'd0, 1'b0);
        for (int i = 0; i < 5; i++) send(8'h11 + 8'(i), 1'b0);
        repeat (700) @(negedge clk);
        chk(rx_count == 3'd4, "R7 rx_count full", int'(rx_count), 4);
        chk(err_overrun == 1'b1, "R11 overrun flag", int'(err_overrun), 1);
        chk(irq == 1'b1, "R12 irq on error", int'(irq), 1);
        for (int i = 0; i < 4; i++) man_read(8'h11 + 8'(i), "R11 stored chars kept");
        chk(rx_count == 3'd0, "R11 fifth char dropped", int'(rx_count), 0);

        // R13 clear
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk({err_frame, err_parity, err_overrun} == 3'b000, "R13 errors cleared",
            int'({err_frame, err_parity, err_overrun}), 0);
        chk(irq == 1'b0, "R12 irq low after clear", int'(irq), 0);

        // R12 data interrupt
        irq_en_err = 1'b0; irq_en_rx = 1'b1;
        send(8'h7E, 1'b0);
        repeat (120) @(negedge clk);
        chk(irq == 1'b1, "R12 irq on data waiting", int'(irq), 1);
        man_read(8'h7E, "R8 data read back");
        chk(irq == 1'b0, "R12 irq low when empty", int'(irq), 0);
        irq_en_rx = 1'b0;
        mon_en = 1'b1;

        // R9 parity error: 8E1 0x01 with parity 0 (should be 1)
        set_cfg(2'd0, 16'd64, 1'b0, 1'b1, 2'd0, 1'b0);
        exp_q.push_back(8'h01);
        raw_frame(16'b0000_0100_0000_0010, 11);
        drain();
        chk(err_parity == 1'b1, "R9 parity error set", int'(err_parity), 1);
        chk(err_frame == 1'b0, "R10 no framing error", int'(err_frame), 0);

        // R10 framing error: 8N2 0x55 with first stop low
        set_cfg(2'd0, 16'd64, 1'b0, 1'b0, 2'd0, 1'b1);
        exp_q.push_back(8'h55);
        raw_frame(16'b0000_0100_1010_1010, 11);
        drain();
        chk(err_frame == 1'b1, "R10 framing error set", int'(err_frame), 1);

        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule